// File: doc/BRIEF.md
# Packed-Config Event Counter Bank

This block is a small bank of four 32-bit event counters that software drives over a simple register bus with separate read and write strobes. A single shared 32-bit control word holds one byte per counter. Five bits inside each byte hold an event code, and that code does two jobs: it picks which incoming strobe the counter follows, and a nonzero value turns the counter on. Clearing the code to zero stops the counter, which then holds its value.

Each counter has its own data register. Software reads it to sample the count and writes it to preload or clear the count. The counters raise no interrupt and carry no overflow flag. They roll over silently at 2^32, so software must sample them often enough to catch every wrap. Event code 0x01 counts every clock. Codes 0x02 to 0x0F follow the matching line of a 16-bit strobe vector. The system maps write transactions to line 0x0B, data beats to line 0x0D and read transactions to line 0x0F.

Top module: `evt_ctr_bank`

## Requirements
- R1: After a synchronous reset the control word and all four counters read as zero.
- R2: The control word is at byte offset 0x234 and counter n's data register is at 0x240 + 12·n. A read request puts the selected value on the read data port in the next cycle, and that port holds it until the next request.
- R3: Counter n's event code is bits [8n+5:8n+1] of the control word. A code stored at a clock edge governs counting from the following edge onward.
- R4: Code 0x01 adds one to the counter at every clock edge.
- R5: A code c in 0x02 to 0x0F adds one at each edge where strobe line c is high, and ignores all other lines. The system wires write transactions to line 0x0B, data beats to 0x0D and read transactions to 0x0F.
- R6: A code of 0x00, or any code of 0x10 or above, leaves the counter unchanged whatever the strobes do.
- R7: Bits 0, 6 and 7 of every control byte are stored and read back as written, and they change no counter's behaviour.
- R8: A write to a data register loads the written value into that counter.
- R9: A counter at 0xFFFFFFFF that counts once reads 0x00000000 afterwards, with no other effect.
- R10: When a data-register write and a counting event hit the same counter at the same edge, the counter takes the written value and the event is lost.
- R11: Reads of any offset other than the five mapped ones return zero, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_strb | input | 16 | Event strobe lines, indexed by event code |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid the cycle after a request |

## Verification
On every cycle the assertions check each counter's step against its code. A cycle code must add exactly one, including the wrap from all-ones to zero. A zero or out-of-range code, or an unselected strobe, must leave the count unchanged. A data write must load its value over any increment. A write outside the control offset must leave the control word alone, and a control read must return the stored word. Only the bench's scenarios show the exact byte positions of the codes, the one-edge delay before a new code takes effect, which strobe line each code follows, that reserved bits are neutral, and that unmapped reads return zero.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int BYTE_W      = 8;
    localparam int EV_W        = 5;
    localparam int EV_LSB      = 1;
    localparam int NUM_STRB    = 16;
    localparam int STRB_IDX_W  = $clog2(NUM_STRB);
    localparam int MAX_CTR     = DATA_W / BYTE_W;
    localparam int DATA_STRIDE = 12;

    localparam logic [ADDR_W-1:0] CTL_OFS   = 12'h234;
    localparam logic [ADDR_W-1:0] DATA_BASE = 12'h240;

    typedef enum logic [EV_W-1:0] {
        EV_OFF    = 5'h00,
        EV_CYCLE  = 5'h01,
        EV_WR_TXN = 5'h0B,
        EV_BEAT   = 5'h0D,
        EV_RD_TXN = 5'h0F
    } ev_code_e;

    typedef struct packed {
        logic                  valid;
        logic                  every_cycle;
        logic [STRB_IDX_W-1:0] idx;
    } ev_sel_t;

    function automatic logic [EV_W-1:0] ctl_code(input logic [DATA_W-1:0] ctl, input int n);
        return ctl[n*BYTE_W + EV_LSB +: EV_W];
    endfunction

    function automatic logic [ADDR_W-1:0] dat_ofs(input int n);
        return DATA_BASE + ADDR_W'(n * DATA_STRIDE);
    endfunction

    function automatic ev_sel_t sel_decode(input logic [EV_W-1:0] code);
        ev_sel_t s;
        s.valid       = (code != EV_OFF) && (code < EV_W'(NUM_STRB));
        s.every_cycle = (code == EV_CYCLE);
        s.idx         = code[STRB_IDX_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/ecb_addr_decode.sv
module ecb_addr_decode
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               ctl_hit,
    output logic [NUM_CTR-1:0] dat_hit
);

    assign ctl_hit = (addr == CTL_OFS);

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_hit
        assign dat_hit[n] = (addr == dat_ofs(n));
    end

endmodule

// File: rtl/ecb_event_select.sv
module ecb_event_select
    import evt_ctr_pkg::*;
(
    input  logic [EV_W-1:0]     code,
    input  logic [NUM_STRB-1:0] ev_strb,
    output logic                inc
);

    ev_sel_t sel;

    always_comb begin
        sel = sel_decode(code);
        inc = sel.valid && (sel.every_cycle || ev_strb[sel.idx]);
    end

endmodule

// File: rtl/ecb_counter.sv
module ecb_counter #(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CTR_W-1:0] load_val,
    input  logic             inc,
    output logic [CTR_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + CTR_W'(1);
        end
    end

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_STRB-1:0] ev_strb,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata
);

    logic                             ctl_hit;
    logic [NUM_CTR-1:0]               dat_hit;
    logic [NUM_CTR-1:0]               dat_wr;
    logic [DATA_W-1:0]                ctl_q;
    logic [NUM_CTR-1:0][DATA_W-1:0]   cnt_flat;
    logic [DATA_W-1:0]                rd_mux;

    ecb_addr_decode #(.NUM_CTR(NUM_CTR)) u_dec (
        .addr    (bus_addr),
        .ctl_hit (ctl_hit),
        .dat_hit (dat_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (bus_wr && ctl_hit) begin
            ctl_q <= bus_wdata;
        end
    end

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        logic inc_n;

        assign dat_wr[n] = bus_wr && dat_hit[n];

        ecb_event_select u_sel (
            .code    (ctl_code(ctl_q, n)),
            .ev_strb (ev_strb),
            .inc     (inc_n)
        );

        ecb_counter #(.CTR_W(DATA_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (dat_wr[n]),
            .load_val (bus_wdata),
            .inc      (inc_n),
            .cnt      (cnt_flat[n])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (ctl_hit) begin
            rd_mux = ctl_q;
        end
        for (int n = 0; n < NUM_CTR; n++) begin
            if (dat_hit[n]) begin
                rd_mux = cnt_flat[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic [NUM_STRB-1:0]            ev_strb,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_wr,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic                           bus_rd,
    input logic [DATA_W-1:0]              bus_rdata,
    input logic [DATA_W-1:0]              ctl_q,
    input logic [NUM_CTR-1:0][DATA_W-1:0] cnt_flat,
    input logic [NUM_CTR-1:0]             dat_wr
);

    // R11: writes away from the control offset leave the control word alone
    assert_ctl_untouched_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != CTL_OFS) |=> $stable(ctl_q));

    // R2: a control read returns the stored word one cycle later
    assert_ctl_read_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == CTL_OFS) |=> bus_rdata == $past(ctl_q));

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
        logic [EV_W-1:0] code_n;
        assign code_n = ctl_code(ctl_q, n);

        // R8, R10: a data write loads its value even if an event is due
        assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
            dat_wr[n] |=> cnt_flat[n] == $past(bus_wdata));

        // R4: cycle code steps by exactly one
        assert_cycle_step_R4: assert property (@(posedge clk) disable iff (rst)
            (!dat_wr[n] && code_n == EV_CYCLE) |=> cnt_flat[n] == $past(cnt_flat[n]) + DATA_W'(1));

        // R9: all-ones wraps to zero
        assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
            (!dat_wr[n] && code_n == EV_CYCLE && cnt_flat[n] == '1) |=> cnt_flat[n] == '0);

        // R6: zero or out-of-range code holds the count
        assert_stopped_R6: assert property (@(posedge clk) disable iff (rst)
            (!dat_wr[n] && (code_n == EV_OFF || code_n >= EV_W'(NUM_STRB))) |=> $stable(cnt_flat[n]));

        // R5: a strobe-driven code with its line low holds the count
        assert_idle_line_R5: assert property (@(posedge clk) disable iff (rst)
            (!dat_wr[n] && code_n > EV_CYCLE && code_n < EV_W'(NUM_STRB)
             && !ev_strb[code_n[STRB_IDX_W-1:0]]) |=> $stable(cnt_flat[n]));
    end

endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_strb   (ev_strb),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ctl_q     (ctl_q),
    .cnt_flat  (cnt_flat),
    .dat_wr    (dat_wr)
);

// File: tb/tb_evt_ctr_bank.sv
module tb_evt_ctr_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ev_strb = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    localparam logic [11:0] A_CTL = 12'h234;

    function automatic logic [11:0] a_dat(input int n);
        return 12'h240 + 12'(12 * n);
    endfunction

    evt_ctr_bank dut (
        .clk       (clk),
        .rst       (rst),
        .ev_strb   (ev_strb),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic rd_seen = 1'b0;
    logic done = 1'b0;

    always @(posedge clk) rd_seen <= bus_rd && !rst;

    // monitor: pops one expectation for every read the design answered
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R2: unexpected read result %h, expected none", bus_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] addr, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.exp = exp;
        e.tag = tag;
        exp_q.push_back(e);
        bus_rd   = 1'b1;
        bus_addr = addr;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic pulses(input logic [15:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_strb = mask;
        end
        @(negedge clk);
        ev_strb = '0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(A_CTL, 32'h0, "R1 ctl");
        for (int n = 0; n < 4; n++) bus_read(a_dat(n), 32'h0, "R1 data");

        // R4, R3: code 0x01 on counter 0; 5 idle edges -> 7 counts
        bus_write(A_CTL, 32'h0000_0002);
        repeat (5) @(negedge clk);
        bus_write(A_CTL, 32'h0);
        bus_read(a_dat(0), 32'd7, "R4 cycle count");

        // R8: write-to-clear every counter
        for (int n = 0; n < 4; n++) bus_write(a_dat(n), 32'h0);
        bus_read(a_dat(0), 32'h0, "R8 clear");

        // R3, R5, R6: 0x0D ctr0, 0x0B ctr1, 0x0F ctr2, 0x10 ctr3
        bus_write(A_CTL, 32'h201E_161A);
        bus_read(A_CTL, 32'h201E_161A, "R3 ctl readback");
        pulses(16'h0800, 3);
        pulses(16'h2000, 5);
        pulses(16'h8000, 2);
        pulses(16'hA800, 4);
        pulses(16'h57FF, 4);
        bus_write(A_CTL, 32'h0);
        bus_read(a_dat(0), 32'd9, "R5 beat ctr0");
        bus_read(a_dat(1), 32'd7, "R5 wr txn ctr1");
        bus_read(a_dat(2), 32'd6, "R5 rd txn ctr2");
        bus_read(a_dat(3), 32'd0, "R6 code 0x10 ctr3");

        // R6: zero code ignores strobes
        pulses(16'hFFFF, 6);
        bus_read(a_dat(0), 32'd9, "R6 stopped ctr0");

        // R7: reserved bits read back and change nothing
        bus_write(A_CTL, 32'hC1C1_C1C1);
        bus_read(A_CTL, 32'hC1C1_C1C1, "R7 reserved readback");
        pulses(16'hFFFF, 4);
        bus_read(a_dat(1), 32'd7, "R7 reserved no count");
        bus_write(a_dat(0), 32'h0);
        bus_write(A_CTL, 32'h0000_00C3);
        bus_write(A_CTL, 32'h0);
        bus_read(a_dat(0), 32'd2, "R7 reserved with cycle code");

        // R8: direct load
        bus_write(a_dat(2), 32'h1234_5678);
        bus_read(a_dat(2), 32'h1234_5678, "R8 load");

        // R9: wrap on counter 3, three counts from 0xFFFFFFFE
        bus_write(a_dat(3), 32'hFFFF_FFFE);
        bus_write(A_CTL, 32'h0200_0000);
        repeat (1) @(negedge clk);
        bus_write(A_CTL, 32'h0);
        bus_read(a_dat(3), 32'h0000_0001, "R9 wrap");

        // R10: load at the same edge as a cycle increment
        bus_write(a_dat(0), 32'h0);
        bus_write(A_CTL, 32'h0000_0002);
        bus_write(a_dat(0), 32'h0000_0100);
        bus_write(A_CTL, 32'h0);
        bus_read(a_dat(0), 32'h0000_0102, "R10 write priority");

        // R11: unmapped offsets
        bus_read(12'h238, 32'h0, "R11 read 0x238");
        bus_read(12'h244, 32'h0, "R11 read 0x244");
        bus_read(12'h270, 32'h0, "R11 read 0x270");
        bus_read(12'h000, 32'h0, "R11 read 0x000");
        bus_write(12'h238, 32'hFFFF_FFFF);
        bus_write(12'h248, 32'hFFFF_FFFF);
        bus_read(A_CTL, 32'h0, "R11 ctl unchanged");
        bus_read(a_dat(2), 32'h1234_5678, "R11 data unchanged");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            summary();
            $finish;
        end
    end

endmodule